// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. A host pushes bytes into a sixteen-entry first-in first-out store through a one-cycle write strobe. Whenever the line is free, the clear-to-send input is active and at least one byte is waiting, the block takes the oldest byte and sends one character: a low start bit, the data bits least significant first, an optional parity bit, then one or two high stop bits. Between characters the line rests high.

The character format comes from an 8-bit mode word and is taken at the moment each character begins. The serial timing is driven by a tick that runs at sixteen times the bit rate. The tick comes either from an internal programmable divider of the system clock or from an external oversampling clock, which the block synchronises. The host sees the number of stored bytes, an empty flag and a sticky flag that records a write refused because the store was full.

Top module: `async_tx_fifo`

## Requirements
- R1: After reset `txd` is 1, `fifo_empty` is 1, `fifo_level` is 0 and `overflow` is 0. The line stays at 1 whenever no character is in progress.
- R2: The store holds up to 16 bytes in arrival order. `fifo_level` gives the number held, and `fifo_empty` is 1 exactly when that number is 0.
- R3: A write made while 16 bytes are held is discarded and leaves the stored bytes unchanged. It sets `overflow`, which stays 1 until reset.
- R4: A character is one start bit at 0, then the data bits LSB first, then parity if enabled, then stop bits at 1. Each bit lasts 16 ticks.
- R5: Mode bit 6 selects data length. 0 sends 8 bits. 1 sends 7 bits, taken from byte bits 6:0.
- R6: Mode bit 5 set adds a parity bit right after the data. Mode bit 4 picks its sense: 0 gives an even count of ones over data plus parity, 1 gives an odd count.
- R7: Mode bit 3 selects one stop bit (0) or two (1). With one tick per clock and bytes waiting, characters start every 16·N+1 clocks, where N is the number of bits in the character.
- R8: With `clk_sel`=0 a tick occurs once every `div_val`+1 clocks. With `clk_sel`=1 a tick occurs once per rising edge of `ext_clk_in`, after a two-stage synchroniser.
- R9: While `cts_n` is 1, no new character starts and waiting bytes stay stored. A character already started runs to its last stop bit.
- R10: The mode word is sampled when a character starts. Changes made while that character is in progress do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the store this cycle |
| wr_data | input | 8 | Byte to store |
| fmt_mode | input | 8 | Format word: bit 6 length, bit 5 parity enable, bit 4 parity sense, bit 3 stop count |
| clk_sel | input | 1 | 0: internal divider tick, 1: external oversampling clock |
| div_val | input | DIV_W | Internal divider setting (tick period minus one) |
| ext_clk_in | input | 1 | External clock at 16 times the bit rate |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial data line |
| fifo_empty | output | 1 | No byte waiting |
| fifo_level | output | LVL_W | Number of stored bytes (0 to 16) |
| overflow | output | 1 | Sticky: a write arrived while full |

## Verification
The hardest situations to reach from the ports are a write that hits a full store, and clear-to-send being withdrawn partway through a character. Both need the store to fill faster than it drains. The bench holds `cts_n` high while it pushes seventeen bytes, checks that only the seventeenth is lost, and then drains the store to confirm order and content. In a separate run it raises `cts_n` a few bit times into a character, then checks that the character completes and that the next byte stays stored until `cts_n` falls again. Every combination of the four format bits is swept with three back-to-back characters, so frame spacing also checks the stop-bit count.

// File: rtl/atx_pkg.sv
// Shared constants, types and the frame builder for the buffered serial transmitter.
// Assumes characters are at most 8 data bits and frames at most 12 bits long.
package atx_pkg;
    localparam int CHAR_W     = 8;
    localparam int FRAME_W    = 12;
    localparam int LEN_W      = 4;
    localparam int MB_SEVEN   = 6;
    localparam int MB_PAR_EN  = 5;
    localparam int MB_PAR_ODD = 4;
    localparam int MB_STOP2   = 3;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    // Assemble the full bit sequence (bit 0 sent first) and its length.
    function automatic frame_t build_frame(input logic [CHAR_W-1:0] d, input logic [7:0] m);
        frame_t     f;
        logic       p;
        logic [2:0] tail;
        p    = (m[MB_SEVEN] ? ^d[6:0] : ^d) ^ m[MB_PAR_ODD];
        tail = m[MB_PAR_EN] ? {2'b11, p} : 3'b111;
        if (m[MB_SEVEN])
            f.bits = {1'b1, tail, d[6:0], 1'b0};
        else
            f.bits = {tail, d, 1'b0};
        f.len = 4'd10 - {3'b000, m[MB_SEVEN]} + {3'b000, m[MB_PAR_EN]} + {3'b000, m[MB_STOP2]};
        return f;
    endfunction
endpackage

// File: rtl/atx_tick_gen.sv
// Oversampling tick source. Produces a one-cycle pulse either every div_val+1
// clocks, or once per rising edge of a synchronised external clock.
// Assumes the external clock is slower than half the system clock.
module atx_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ext_clk_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic             ext_s1, ext_s2, ext_s3;
    logic             int_hit;

    assign int_hit = (div_cnt >= div_val);

    // Internal divider counter, restarting at each internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cnt <= '0;
        else if (int_hit) div_cnt <= '0;
        else              div_cnt <= div_cnt + 1'b1;
    end

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            ext_s3 <= 1'b0;
        end else begin
            ext_s1 <= ext_clk_in;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
        end
    end

    // Registered tick from whichever source is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)       tick <= 1'b0;
        else if (clk_sel) tick <= ext_s2 & ~ext_s3;
        else              tick <= int_hit;
    end

    assert_ext_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && tick) |=> (!tick || !clk_sel));
    assert_div_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel && tick && div_val != '0) |=> (!tick || clk_sel || div_val == '0));
endmodule

// File: rtl/atx_fifo.sv
// Byte store with occupancy count. Writes to a full store are dropped and
// recorded in a sticky flag. Assumes rd_en is raised only when not empty.
module atx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             overflow
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, accept;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign accept  = wr_en && !full;
    assign rd_data = mem[rd_ptr];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_data;
    end

    // Pointers, occupancy and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({accept, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));
    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/atx_shifter.sv
// Character serializer. When idle, with a byte waiting and clear-to-send
// granted, it takes the byte, builds the frame from the current mode word and
// shifts it out, one bit per OS ticks. Assumes cts_ok is already synchronous.
module atx_shifter
    import atx_pkg::*;
#(
    parameter int OS = 16,
    localparam int OS_W = $clog2(OS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cts_ok,
    input  logic              fifo_has,
    input  logic [CHAR_W-1:0] char_in,
    input  logic [7:0]        mode,
    output logic              pop,
    output logic              txd
);
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   bits_left;
    logic [OS_W-1:0]    os_cnt;
    logic               busy, start;
    frame_t             nxt;

    assign busy  = (bits_left != '0);
    assign start = !busy && fifo_has && cts_ok;
    assign pop   = start;
    assign nxt   = build_frame(char_in, mode);
    assign txd   = shreg[0];

    // Frame load, oversample counting and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            os_cnt    <= '0;
        end else if (start) begin
            shreg     <= nxt.bits;
            bits_left <= nxt.len;
            os_cnt    <= '0;
        end else if (busy && tick) begin
            if (os_cnt == OS_W'(OS - 1)) begin
                os_cnt    <= '0;
                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
            end else begin
                os_cnt <= os_cnt + 1'b1;
            end
        end
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(txd));
    assert_cts_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cts_ok) |=> !busy);
endmodule

// File: rtl/async_tx_fifo.sv
// Top of the buffered asynchronous transmitter: byte store, tick source and
// serializer, with clear-to-send synchronised on entry.
// Assumes DEPTH is a power of two.
module async_tx_fifo
    import atx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 12,
    parameter int OS    = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       fmt_mode,
    input  logic             clk_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ext_clk_in,
    input  logic             cts_n,
    output logic             txd,
    output logic             fifo_empty,
    output logic [LVL_W-1:0] fifo_level,
    output logic             overflow
);
    logic              cts_s1, cts_s2;
    logic              tick, pop;
    logic [CHAR_W-1:0] head;

    // Clear-to-send synchroniser, reset to "not clear".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_s1 <= 1'b1;
            cts_s2 <= 1'b1;
        end else begin
            cts_s1 <= cts_n;
            cts_s2 <= cts_s1;
        end
    end

    atx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (pop),
        .rd_data  (head),
        .level    (fifo_level),
        .empty    (fifo_empty),
        .overflow (overflow)
    );

    atx_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (clk_sel),
        .div_val    (div_val),
        .ext_clk_in (ext_clk_in),
        .tick       (tick)
    );

    atx_shifter #(.OS(OS)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cts_ok   (!cts_s2),
        .fifo_has (!fifo_empty),
        .char_in  (head),
        .mode     (fmt_mode),
        .pop      (pop),
        .txd      (txd)
    );
endmodule

// File: tb/async_tx_fifo_tb.sv
// Self-checking bench: sweeps every format combination, the full-store case,
// flow control mid-character, mode changes mid-character and both tick sources.
module async_tx_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] fmt_mode = '0;
    logic       clk_sel = 1'b0;
    logic [11:0] div_val = '0;
    logic       ext_clk_in = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd, fifo_empty, overflow;
    logic [4:0] fifo_level;

    int  n_checks = 0;
    int  n_errors = 0;
    longint cyc = 0;
    bit  ext_run = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_tx_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fmt_mode(fmt_mode), .clk_sel(clk_sel), .div_val(div_val),
        .ext_clk_in(ext_clk_in), .cts_n(cts_n), .txd(txd),
        .fifo_empty(fifo_empty), .fifo_level(fifo_level), .overflow(overflow)
    );

    initial forever begin
        @(negedge clk);
        if (ext_run) ext_clk_in = ~ext_clk_in;
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [7:0] m);
        return 1 + (m[6] ? 7 : 8) + (m[5] ? 1 : 0) + (m[3] ? 2 : 1);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [7:0] m, input int k);
        int   nd;
        logic p;
        nd = m[6] ? 7 : 8;
        if (k == 0) return 1'b0;
        if (k <= nd) return d[k-1];
        if (m[5] && k == nd + 1) begin
            p = m[4];
            for (int i = 0; i < nd; i++) p = p ^ d[i];
            return p;
        end
        return 1'b1;
    endfunction

    function automatic string tag_of(input logic [7:0] m, input int k);
        int nd;
        nd = m[6] ? 7 : 8;
        if (k == 0) return "R4";
        if (k <= nd) return m[6] ? "R5" : "R4";
        if (m[5] && k == nd + 1) return "R6";
        return "R7";
    endfunction

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for a start bit, then sample each bit at its centre.
    task automatic expect_frame(input logic [7:0] d, input logic [7:0] m, input int spb, output longint t0);
        int w;
        int n;
        w = 0;
        while (txd !== 1'b0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(w < 5000, "R4", "start bit seen", w, 0);
        t0 = cyc;
        n = nbits_of(m);
        idle(spb / 2);
        for (int k = 0; k < n; k++) begin
            chk(txd === exp_bit(d, m, k), tag_of(m, k), $sformatf("bit %0d of 0x%02h mode 0x%02h", k, d, m),
                txd, exp_bit(d, m, k));
            if (k != n - 1) idle(spb);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        longint t0, t1, t2;
        logic [7:0] m, b0, b1, b2;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
        chk(fifo_empty === 1'b1, "R1", "empty after reset", fifo_empty, 1);
        chk(fifo_level === 5'd0, "R1", "level after reset", fifo_level, 0);
        chk(overflow === 1'b0, "R1", "overflow after reset", overflow, 0);

        // Sweep all sixteen format combinations, three characters each (R4..R7, R9, R2).
        for (int c = 0; c < 16; c++) begin
            m  = 8'(c) << 3;
            b0 = 8'(c * 37 + 5);
            b1 = ~b0;
            b2 = 8'(c * 11) ^ 8'h5A;
            cts_n = 1'b1;
            fmt_mode = m;
            push(b0);
            push(b1);
            push(b2);
            idle(40);
            chk(txd === 1'b1, "R9", "line held while cts_n high", txd, 1);
            chk(fifo_level === 5'd3, "R2", "level after three writes", fifo_level, 3);
            chk(fifo_empty === 1'b0, "R2", "not empty with three", fifo_empty, 0);
            cts_n = 1'b0;
            expect_frame(b0, m, 16, t0);
            expect_frame(b1, m, 16, t1);
            expect_frame(b2, m, 16, t2);
            chk(t1 - t0 == 16 * nbits_of(m) + 1, "R7", "frame spacing 1", t1 - t0, 16 * nbits_of(m) + 1);
            chk(t2 - t1 == 16 * nbits_of(m) + 1, "R7", "frame spacing 2", t2 - t1, 16 * nbits_of(m) + 1);
            chk(fifo_empty === 1'b1, "R2", "empty after drain", fifo_empty, 1);
            idle(20);
            chk(txd === 1'b1, "R1", "idle high after drain", txd, 1);
        end

        // R3: overfill with cts_n high, then drain and confirm order and loss.
        cts_n = 1'b1;
        fmt_mode = 8'h00;
        for (int i = 0; i < 16; i++) push(8'(i * 17 + 3));
        chk(fifo_level === 5'd16, "R2", "level when full", fifo_level, 16);
        chk(overflow === 1'b0, "R3", "no overflow at exactly full", overflow, 0);
        push(8'hEE);
        chk(fifo_level === 5'd16, "R3", "level after dropped write", fifo_level, 16);
        chk(overflow === 1'b1, "R3", "overflow set", overflow, 1);
        cts_n = 1'b0;
        for (int i = 0; i < 16; i++) expect_frame(8'(i * 17 + 3), 8'h00, 16, t0);
        idle(40);
        chk(fifo_empty === 1'b1, "R3", "dropped byte never stored", fifo_empty, 1);
        chk(txd === 1'b1, "R3", "no extra character", txd, 1);
        chk(overflow === 1'b1, "R3", "overflow sticky", overflow, 1);

        // R9: withdraw clear-to-send partway through a character.
        cts_n = 1'b1;
        fmt_mode = 8'h28;
        push(8'hC3);
        push(8'h3C);
        cts_n = 1'b0;
        fork
            begin
                idle(40);
                cts_n = 1'b1;
            end
            expect_frame(8'hC3, 8'h28, 16, t0);
        join
        idle(300);
        chk(txd === 1'b1, "R9", "no new character after cts_n rise", txd, 1);
        chk(fifo_level === 5'd1, "R9", "byte kept waiting", fifo_level, 1);
        cts_n = 1'b0;
        expect_frame(8'h3C, 8'h28, 16, t0);
        idle(40);

        // R10: mode changes during a character do not affect it.
        cts_n = 1'b1;
        fmt_mode = 8'h00;
        push(8'h96);
        cts_n = 1'b0;
        fork
            begin
                while (txd !== 1'b0) @(negedge clk);
                idle(3);
                fmt_mode = 8'h78;
            end
            expect_frame(8'h96, 8'h00, 16, t0);
        join
        idle(40);

        // R8: internal divider of four clocks per tick.
        cts_n = 1'b1;
        fmt_mode = 8'h30;
        div_val = 12'd3;
        push(8'h5B);
        cts_n = 1'b0;
        expect_frame(8'h5B, 8'h30, 64, t0);
        idle(80);

        // R8: external oversampling clock, one tick per two system clocks.
        cts_n = 1'b1;
        clk_sel = 1'b1;
        ext_run = 1'b1;
        fmt_mode = 8'h48;
        push(8'hA7);
        cts_n = 1'b0;
        expect_frame(8'hA7, 8'h48, 32, t0);
        idle(60);
        chk(txd === 1'b1, "R8", "idle after external-clock frame", txd, 1);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule